// File: doc/BRIEF.md
# Conversion Queue Status Flags

This block is the 16-bit status word of a two-queue analog conversion sequencer. For each queue it keeps three sticky event bits: a completion flag, a pause flag and a trigger overrun flag. The conversion engine reports events as one-cycle strobes. For each completed command word it reports the command word location, the channel field it carried and the queue it belonged to. The block works out whether that command word ended its queue, and it sets the completion flag in the same clock edge.

Software reads the word through a simple register port. A set bit is cleared by a two-step handshake: software must first read the bit as one, then write a zero to it. A zero written without that earlier read leaves the bit set. Each queue also raises an interrupt request when its completion flag is set and its enable is on. The request carries that queue's level value.

Top module: `qstat_reg`

## Requirements
- R1: After reset the read word is 0x0000, both interrupt requests are low and both level outputs are zero.
- R2: Read word layout: bit 15 queue 1 completion, bit 14 queue 1 pause, bit 13 queue 2 completion, bit 12 queue 2 pause, bit 11 queue 1 trigger overrun, bit 10 queue 2 trigger overrun, bits 9:6 the queue state input, bits 5:0 the command pointer input.
- R3: A queue 1 done strobe whose location equals the queue 2 begin pointer minus one (modulo 64) sets the queue 1 completion flag at that clock edge.
- R4: A done strobe whose channel field is 63 (end-of-queue code) sets that queue's completion flag.
- R5: A done strobe at location 63 (the last of 64 command word locations) sets that queue's completion flag. The queue 2 begin pointer does not end queue 2.
- R6: A done strobe that meets no end condition leaves the completion flag unchanged.
- R7: Pause and trigger overrun strobes (bit 0 queue 1, bit 1 queue 2) set their flags.
- R8: Writing zero to a set bit that has not been read as one since its last write leaves the bit set.
- R9: A read returning a bit as one arms it. A later write of zero clears the bit. Any write to the bit disarms it, so a write of one followed by a write of zero does not clear it.
- R10: Writing one to a flag has no effect. Writes never change bits 9:0.
- R11: When a set strobe and a valid clear fall in the same cycle, the flag stays one.
- R12: A queue's interrupt request is high exactly while its completion flag is set and its enable is high, and its level output then equals its level input (zero otherwise). The flags are set whatever the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data (combinational) |
| q_state_i | input | 4 | Queue state shown in the read-only field |
| cmd_ptr_i | input | 6 | Command pointer shown in the read-only field |
| done_i | input | 2 | Command word completed, one bit per queue |
| done_ptr_i | input | 6 | Location of the completed command word |
| done_chan_i | input | 6 | Channel field of the completed command word |
| q2_begin_i | input | 6 | Queue 2 begin pointer |
| pause_i | input | 2 | Pause event per queue |
| trig_ovr_i | input | 2 | Trigger overrun event per queue |
| irq_en_i | input | 2 | Completion interrupt enable per queue |
| q1_lvl_i | input | 5 | Queue 1 interrupt level |
| q2_lvl_i | input | 5 | Queue 2 interrupt level |
| irq_req_o | output | 2 | Interrupt request per queue |
| q1_irq_lvl_o | output | 5 | Queue 1 requested level, zero when idle |
| q2_irq_lvl_o | output | 5 | Queue 2 requested level, zero when idle |

## Verification
A hardware set strobe and a software clear can land on the same clock edge. The bench provokes this by reading queue 1's completion flag as one, then driving a zero write to it in the same cycle as a fresh end-of-queue done strobe. It then reads the word back and expects the flag still set. In a second case, a flag that was read as zero and is set afterwards receives a zero write, and the flag must survive. This shows that arming follows the value returned by the read and not the value at the moment of the write.

// File: rtl/qstat_pkg.sv
package qstat_pkg;
  localparam int REG_W  = 16;
  localparam int NUM_Q  = 2;
  localparam int NFLAG  = 6;

  // index order of the clearable bits; read bit = REG_W-1-index
  typedef enum int unsigned {
    FLG_CF1  = 0,
    FLG_PF1  = 1,
    FLG_CF2  = 2,
    FLG_PF2  = 3,
    FLG_TOR1 = 4,
    FLG_TOR2 = 5
  } flag_idx_e;

  function automatic int flag_bit(input int idx);
    return REG_W - 1 - idx;
  endfunction
endpackage

// File: rtl/qstat_eoq.sv
module qstat_eoq #(
  parameter int PTR_W     = 6,
  parameter int CHAN_W    = 6,
  parameter bit USE_BEGIN = 1'b1
) (
  input  logic              done_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic [PTR_W-1:0]  begin_i,
  output logic              end_o
);
  localparam logic [CHAN_W-1:0] EOQ_CODE = {CHAN_W{1'b1}};
  localparam logic [PTR_W-1:0]  LAST_LOC = {PTR_W{1'b1}};

  logic [PTR_W-1:0] prev_begin;
  logic hit_begin, hit_code, hit_last;

  always_comb begin
    prev_begin = begin_i - PTR_W'(1);
    hit_begin  = USE_BEGIN && (ptr_i == prev_begin);
    hit_code   = (chan_i == EOQ_CODE);
    hit_last   = (ptr_i == LAST_LOC);
    end_o      = done_i && (hit_begin || hit_code || hit_last);
  end
endmodule

// File: rtl/qstat_flag.sv
module qstat_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic flag_q, arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (set_i)                          flag_q <= 1'b1;
      else if (wr_i && !wbit_i && arm_q)  flag_q <= 1'b0;
      // any write disarms; a read that returns one arms
      if (wr_i)                           arm_q  <= 1'b0;
      else if (rd_i && flag_q)            arm_q  <= 1'b1;
    end
  end

  assign flag_o = flag_q;

  assert_set_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
  assert_no_unarmed_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !arm_q) |=> flag_q);
  assert_write_one_keeps_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && wr_i && wbit_i) |=> flag_q);
  assert_write_disarms_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !arm_q);
endmodule

// File: rtl/qstat_irq.sv
module qstat_irq #(
  parameter int LVL_W = 5
) (
  input  logic             flag_i,
  input  logic             en_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic             req_o,
  output logic [LVL_W-1:0] lvl_o
);
  always_comb begin
    req_o = flag_i && en_i;
    lvl_o = req_o ? lvl_i : '0;
  end
endmodule

// File: rtl/qstat_reg.sv
module qstat_reg
  import qstat_pkg::*;
#(
  parameter int PTR_W   = 6,
  parameter int CHAN_W  = 6,
  parameter int STATE_W = 4,
  parameter int LVL_W   = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_en_i,
  input  logic               wr_en_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  input  logic [STATE_W-1:0] q_state_i,
  input  logic [PTR_W-1:0]   cmd_ptr_i,
  input  logic [NUM_Q-1:0]   done_i,
  input  logic [PTR_W-1:0]   done_ptr_i,
  input  logic [CHAN_W-1:0]  done_chan_i,
  input  logic [PTR_W-1:0]   q2_begin_i,
  input  logic [NUM_Q-1:0]   pause_i,
  input  logic [NUM_Q-1:0]   trig_ovr_i,
  input  logic [NUM_Q-1:0]   irq_en_i,
  input  logic [LVL_W-1:0]   q1_lvl_i,
  input  logic [LVL_W-1:0]   q2_lvl_i,
  output logic [NUM_Q-1:0]   irq_req_o,
  output logic [LVL_W-1:0]   q1_irq_lvl_o,
  output logic [LVL_W-1:0]   q2_irq_lvl_o
);
  localparam int RO_W = PTR_W + STATE_W;

  logic [NUM_Q-1:0] q_end;
  logic [NFLAG-1:0] set_vec, flag_vec, wbit_vec;
  logic [LVL_W-1:0] lvl_in  [NUM_Q];
  logic [LVL_W-1:0] lvl_out [NUM_Q];

  // only queue 1 is bounded by the queue 2 begin pointer
  for (genvar q = 0; q < NUM_Q; q++) begin : g_eoq
    qstat_eoq #(
      .PTR_W(PTR_W), .CHAN_W(CHAN_W), .USE_BEGIN(q == 0)
    ) u_eoq (
      .done_i (done_i[q]),
      .ptr_i  (done_ptr_i),
      .chan_i (done_chan_i),
      .begin_i(q2_begin_i),
      .end_o  (q_end[q])
    );
  end

  always_comb begin
    set_vec[FLG_CF1]  = q_end[0];
    set_vec[FLG_PF1]  = pause_i[0];
    set_vec[FLG_CF2]  = q_end[1];
    set_vec[FLG_PF2]  = pause_i[1];
    set_vec[FLG_TOR1] = trig_ovr_i[0];
    set_vec[FLG_TOR2] = trig_ovr_i[1];
    for (int i = 0; i < NFLAG; i++) wbit_vec[i] = wdata_i[flag_bit(i)];
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    qstat_flag u_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_vec[i]),
      .rd_i  (rd_en_i),
      .wr_i  (wr_en_i),
      .wbit_i(wbit_vec[i]),
      .flag_o(flag_vec[i])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NFLAG; i++) rdata_o[flag_bit(i)] = flag_vec[i];
    rdata_o[PTR_W +: STATE_W] = q_state_i;
    rdata_o[PTR_W-1:0]        = cmd_ptr_i;
  end

  assign lvl_in[0] = q1_lvl_i;
  assign lvl_in[1] = q2_lvl_i;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_irq
    qstat_irq #(.LVL_W(LVL_W)) u_irq (
      .flag_i(flag_vec[2*q]),
      .en_i  (irq_en_i[q]),
      .lvl_i (lvl_in[q]),
      .req_o (irq_req_o[q]),
      .lvl_o (lvl_out[q])
    );
  end

  assign q1_irq_lvl_o = lvl_out[0];
  assign q2_irq_lvl_o = lvl_out[1];

  assert_code_sets_cf1_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i[0] && done_chan_i == {CHAN_W{1'b1}}) |=> rdata_o[REG_W-1]);
  assert_last_sets_cf2_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i[1] && done_ptr_i == {PTR_W{1'b1}}) |=> rdata_o[REG_W-3]);
  assert_irq_needs_flag_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o[0] |-> (rdata_o[REG_W-1] && irq_en_i[0]));
  assert_ro_field_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[RO_W-1:0] == {q_state_i, cmd_ptr_i});
endmodule

// File: tb/qstat_reg_tb.sv
module qstat_reg_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic rd_en_i = 0, wr_en_i = 0;
  logic [15:0] wdata_i = '0, rdata_o;
  logic [3:0] q_state_i = '0;
  logic [5:0] cmd_ptr_i = '0, done_ptr_i = '0, done_chan_i = '0, q2_begin_i = '0;
  logic [1:0] done_i = '0, pause_i = '0, trig_ovr_i = '0, irq_en_i = '0, irq_req_o;
  logic [4:0] q1_lvl_i = '0, q2_lvl_i = '0, q1_irq_lvl_o, q2_irq_lvl_o;
  int checks = 0, errors = 0;

  always #5 clk_i = ~clk_i;

  qstat_reg dut_i (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_read(output logic [15:0] v);
    @(negedge clk_i); rd_en_i = 1; #1 v = rdata_o;
    @(negedge clk_i); rd_en_i = 0;
  endtask

  task automatic do_write(input logic [15:0] d);
    @(negedge clk_i); wr_en_i = 1; wdata_i = d;
    @(negedge clk_i); wr_en_i = 0;
  endtask

  task automatic done(input int q, input logic [5:0] ptr, input logic [5:0] ch);
    @(negedge clk_i); done_i[q] = 1; done_ptr_i = ptr; done_chan_i = ch;
    @(negedge clk_i); done_i = '0;
  endtask

  task automatic clear_all();
    logic [15:0] v;
    do_read(v); do_write(16'h0000);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    check("R1 rdata", rdata_o, 16'h0000);
    check("R1 irq", {irq_req_o, q1_irq_lvl_o, q2_irq_lvl_o}, '0);
  endtask

  task automatic t_ro_fields();
    @(negedge clk_i); q_state_i = 4'hA; cmd_ptr_i = 6'h15;
    #1 check("R2 ro field", rdata_o, {6'b0, 4'hA, 6'h15});
    do_write(16'h0000); do_write(16'hFFFF);
    check("R10 ro write", rdata_o, {6'b0, 4'hA, 6'h15});
    @(negedge clk_i); q_state_i = '0; cmd_ptr_i = '0;
  endtask

  task automatic t_bq2_end();
    logic [15:0] v;
    q2_begin_i = 6'd10;
    done(0, 6'd5, 6'd3);
    check("R6 no end", rdata_o[15], 1'b0);
    done(0, 6'd9, 6'd3);
    check("R3 cf1 begin-1", rdata_o, 16'h8000);
    do_read(v);
    check("R9 read value", v[15], 1'b1);
    do_write(16'h7FFF);
    check("R9 clear after read", rdata_o[15], 1'b0);
    q2_begin_i = 6'd0;
    done(0, 6'd62, 6'd1);
    check("R6 no end2", rdata_o[15], 1'b0);
  endtask

  task automatic t_code_end();
    logic [15:0] v;
    done(0, 6'd20, 6'd63);
    check("R4 cf1 code", rdata_o[15], 1'b1);
    do_write(16'h0000);
    check("R8 unarmed clear", rdata_o[15], 1'b1);
    do_read(v); do_write(16'hFFFF);
    check("R10 write one", rdata_o[15], 1'b1);
    do_write(16'h0000);
    check("R9 disarmed by write", rdata_o[15], 1'b1);
    done(1, 6'd4, 6'd63);
    check("R4 cf2 code", rdata_o[13], 1'b1);
    clear_all();
    check("R9 clear all", rdata_o, 16'h0000);
  endtask

  task automatic t_last_end();
    done(0, 6'd63, 6'd2);
    check("R5 cf1 last", rdata_o[15], 1'b1);
    q2_begin_i = 6'd30;
    done(1, 6'd29, 6'd2);
    check("R5 q2 ignores begin", rdata_o[13], 1'b0);
    done(1, 6'd63, 6'd2);
    check("R5 cf2 last", rdata_o[13], 1'b1);
    clear_all();
  endtask

  task automatic t_pause_tor();
    @(negedge clk_i); pause_i = 2'b11; trig_ovr_i = 2'b11;
    @(negedge clk_i); pause_i = '0; trig_ovr_i = '0;
    check("R7 pf tor", rdata_o, 16'h5C00);
    clear_all();
    check("R7 cleared", rdata_o, 16'h0000);
  endtask

  task automatic t_read_then_set();
    logic [15:0] v;
    do_read(v);
    done(0, 6'd63, 6'd0);
    do_write(16'h0000);
    check("R8 read zero then set", rdata_o[15], 1'b1);
    clear_all();
  endtask

  task automatic t_collision();
    logic [15:0] v;
    done(0, 6'd63, 6'd0);
    do_read(v);
    @(negedge clk_i); wr_en_i = 1; wdata_i = 16'h0000;
    done_i[0] = 1; done_ptr_i = 6'd63; done_chan_i = 6'd0;
    @(negedge clk_i); wr_en_i = 0; done_i = '0;
    check("R11 set beats clear", rdata_o[15], 1'b1);
    clear_all();
    check("R11 later clear", rdata_o[15], 1'b0);
  endtask

  task automatic t_irq();
    irq_en_i = 2'b01; q1_lvl_i = 5'd7; q2_lvl_i = 5'd19;
    done(0, 6'd63, 6'd0);
    check("R12 q1 req", {irq_req_o, q1_irq_lvl_o}, {2'b01, 5'd7});
    done(1, 6'd63, 6'd0);
    check("R12 q2 flag no enable", {rdata_o[13], irq_req_o[1], q2_irq_lvl_o}, {1'b1, 1'b0, 5'd0});
    @(negedge clk_i); irq_en_i = 2'b11;
    #1 check("R12 q2 enabled", {irq_req_o, q2_irq_lvl_o}, {2'b11, 5'd19});
    clear_all();
    check("R12 cleared", {irq_req_o, q1_irq_lvl_o, q2_irq_lvl_o}, '0);
    irq_en_i = '0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1;
        t_reset(); t_ro_fields(); t_bq2_end(); t_code_end(); t_last_end();
        t_pause_tor(); t_read_then_set(); t_collision(); t_irq();
      end
      begin
        repeat (20000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule